// File: doc/BRIEF.md
# Snoopy MESI Bus Controller

This block models cache coherence for one shared memory word across several cores. Each core owns a line controller that keeps its copy of the word in one of four states: modified, exclusive, shared or invalid. Requests that cannot be served locally go to a central bus. The bus grants one of them at a time in round-robin order and broadcasts it to every other core. It completes the transaction only when all other cores have acknowledged.

A core may issue a plain read, a plain write, or a locked fetch-and-add. The fetch-and-add performs load, add and store as one indivisible step, and the core refuses to acknowledge any snoop until the store has landed. A write that wins the bus after its own copy was invalidated is refused (NACK). The core then fetches the line with a read transaction and asks for write ownership again.

Top module: `mesi_snoop_bus`

## Requirements
- R1: After reset every line reads invalid (line_state code 0 per core), mem_word is 0, no req_done is high and bus_valid is low.
- R2: A read miss fills the line as exclusive (code 2) when no other core holds it, and as shared (code 1) otherwise. Any other core holding it in E or M drops to S. The read returns the current word on rsp_data.
- R3: A core in M that snoops another core's read copies its word to mem_word, drops to S, and its word is the one the reader receives.
- R4: A write (req_op 1) to a line held in E or M completes without a bus transaction and leaves the line in M (code 3).
- R5: A write from S wins the bus as an ownership request. Every other copy becomes invalid and the writer ends in M.
- R6: The bus carries one transaction at a time. bus_valid stays high with a fixed bus_owner until every other core has acknowledged.
- R7: When several cores wait at once, the grant goes to the first waiting core at or after the one following the previous grant, wrapping from N-1 to 0.
- R8: An ownership request granted while the requester's line is invalid is flagged by bus_nack during that transaction. It is carried out as a read fill, and the core then requests ownership again.
- R9: A fetch-and-add (req_op 2) returns the old word, leaves old+operand in the line in M, and holds off acknowledgement of any snoop until its store is done. A concurrent reader therefore sees the sum.
- R10: At no time do two cores hold the line in E or M, and no core holds S while another holds E or M.
- R11: Measured from the clock edge that accepts a request, req_done rises 1 cycle later for a read hit or local write, 3 cycles later for an uncontended miss or upgrade, and 4 cycles later for a fetch-and-add on an M or E line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Per-core request, held until that core's req_done |
| req_op | input | 2*N | Per-core operation: 0 read, 1 write, 2 fetch-and-add |
| req_data | input | N*W | Per-core write data or add operand |
| req_done | output | N | Per-core one-cycle completion pulse |
| rsp_data | output | N*W | Per-core read value or old value from fetch-and-add |
| line_state | output | 2*N | Per-core line state: 0 I, 1 S, 2 E, 3 M |
| mem_word | output | W | Memory copy of the word |
| bus_valid | output | 1 | A bus transaction is in progress |
| bus_owner | output | $clog2(N) | Core that owns the current transaction |
| bus_wr | output | 1 | Current transaction is an ownership request |
| bus_nack | output | 1 | Current transaction is a refused write replaced by a fill |

## Verification
A read hit or a local write raises req_done one cycle after the accepting edge. An uncontended miss or upgrade needs three cycles (wait, grant, commit). A fetch-and-add on an owned line needs four. A snoop aimed at a core busy with a fetch-and-add stretches bus_valid to three cycles instead of one. The bench drives and samples on the falling edge and records the cycle count from drive to req_done. It compares that count and the returned word with these figures. Between operations it compares line_state and mem_word with its own model on every clock, and it checks the single-writer rule on every clock.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lstate_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_ADD = 2'd2
  } op_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_WAIT,
    C_LOAD,
    C_ADD,
    C_STORE,
    C_DONE
  } cphase_t;
endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic [$clog2(N)-1:0] gnt,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  // scan downward so the lowest distance from ptr wins
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        gnt = IW'(idx);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take) ptr <= (gnt == IW'(N - 1)) ? '0 : gnt + 1'b1;
  end

  p_grant_waiting_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> req[gnt]);
endmodule

// File: rtl/mesi_bus_ctl.sv
module mesi_bus_ctl
  import mesi_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         bus_req,
  input  logic [N-1:0]         want_wr,
  input  logic [2*N-1:0]       st_flat,
  input  logic [N*W-1:0]       data_flat,
  input  logic [N-1:0]         ack,
  output logic                 bus_valid,
  output logic [$clog2(N)-1:0] owner,
  output logic                 bus_wr,
  output logic                 bus_nack,
  output logic                 commit,
  output logic                 shared,
  output logic [W-1:0]         fill_data,
  output logic [W-1:0]         mem_word
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] gnt;
  logic          any;
  logic [1:0]    g_st;
  logic          m_hit;
  logic [W-1:0]  m_data;
  logic          all_ack;

  mesi_rr_arb #(.N(N)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (bus_req),
    .take (!bus_valid && any),
    .gnt  (gnt),
    .any  (any)
  );

  assign g_st = st_flat[2*int'(gnt) +: 2];

  always_comb begin
    all_ack = 1'b1;
    shared  = 1'b0;
    m_hit   = 1'b0;
    m_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) != owner) begin
        if (!ack[i]) all_ack = 1'b0;
        if (st_flat[2*i +: 2] != LS_I) shared = 1'b1;
        if (st_flat[2*i +: 2] == LS_M) begin
          m_hit  = 1'b1;
          m_data = data_flat[i*W +: W];
        end
      end
    end
  end

  assign commit    = bus_valid && all_ack;
  assign fill_data = m_hit ? m_data : mem_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      owner     <= '0;
      bus_wr    <= 1'b0;
      bus_nack  <= 1'b0;
      mem_word  <= '0;
    end else if (!bus_valid) begin
      if (any) begin
        bus_valid <= 1'b1;
        owner     <= gnt;
        bus_wr    <= want_wr[gnt] && (g_st != LS_I);
        bus_nack  <= want_wr[gnt] && (g_st == LS_I);
      end
    end else if (commit) begin
      bus_valid <= 1'b0;
      bus_wr    <= 1'b0;
      bus_nack  <= 1'b0;
      if (!bus_wr && m_hit) mem_word <= m_data;
    end
  end

  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !commit) |=> (bus_valid && $stable(owner) && $stable(bus_wr)));

  p_owner_waits_r6: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_req[owner]);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int N   = 4,
  parameter int W   = 16,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [W-1:0]         req_data,
  input  logic                 bus_valid,
  input  logic [$clog2(N)-1:0] owner,
  input  logic                 bus_wr,
  input  logic                 commit,
  input  logic                 shared,
  input  logic [W-1:0]         fill_data,
  output logic [1:0]           st_o,
  output logic [W-1:0]         data_o,
  output logic                 bus_req,
  output logic                 want_wr,
  output logic                 ack,
  output logic                 req_done,
  output logic [W-1:0]         rsp_data
);
  localparam int IW = $clog2(N);

  cphase_t      ph;
  lstate_t      st;
  logic [W-1:0] data;
  logic [W-1:0] acc;
  logic         cur_wr;
  logic         is_owner;
  logic         snooped;

  assign is_owner = bus_valid && (owner == IW'(IDX));
  assign snooped  = commit && !is_owner;
  assign st_o     = st;
  assign data_o   = data;
  assign bus_req  = (ph == C_WAIT);
  assign req_done = (ph == C_DONE);
  assign ack      = !(ph == C_LOAD || ph == C_ADD || ph == C_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= C_IDLE;
      st       <= LS_I;
      data     <= '0;
      acc      <= '0;
      rsp_data <= '0;
      cur_wr   <= 1'b0;
      want_wr  <= 1'b0;
    end else begin
      if (snooped) begin
        if (bus_wr) st <= LS_I;
        else if (st == LS_M || st == LS_E) st <= LS_S;
      end
      case (ph)
        C_IDLE: begin
          if (req_valid && !bus_valid) begin
            cur_wr <= (req_op == OP_WR);
            case (req_op)
              OP_WR: begin
                if (st == LS_M || st == LS_E) begin
                  data <= req_data;
                  st   <= LS_M;
                  ph   <= C_DONE;
                end else begin
                  want_wr <= 1'b1;
                  ph      <= C_WAIT;
                end
              end
              OP_ADD: begin
                if (st == LS_M || st == LS_E) ph <= C_LOAD;
                else begin
                  want_wr <= 1'b1;
                  ph      <= C_WAIT;
                end
              end
              default: begin
                if (st != LS_I) begin
                  rsp_data <= data;
                  ph       <= C_DONE;
                end else begin
                  want_wr <= 1'b0;
                  ph      <= C_WAIT;
                end
              end
            endcase
          end
        end
        C_WAIT: begin
          if (commit && is_owner) begin
            if (bus_wr) begin
              st <= LS_M;
              if (cur_wr) begin
                data <= req_data;
                ph   <= C_DONE;
              end else begin
                ph <= C_LOAD;
              end
            end else begin
              data <= fill_data;
              st   <= shared ? LS_S : LS_E;
              if (!want_wr) begin
                rsp_data <= fill_data;
                ph       <= C_DONE;
              end
            end
          end
        end
        C_LOAD: begin
          rsp_data <= data;
          acc      <= data;
          ph       <= C_ADD;
        end
        C_ADD: begin
          acc <= acc + req_data;
          ph  <= C_STORE;
        end
        C_STORE: begin
          data <= acc;
          st   <= LS_M;
          ph   <= C_DONE;
        end
        default: begin
          want_wr <= 1'b0;
          ph      <= C_IDLE;
        end
      endcase
    end
  end

  p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (!ack && !is_owner) |-> !commit);

  p_upgrade_to_m_r5: assert property (@(posedge clk) disable iff (rst)
    (commit && is_owner && bus_wr) |=> (st == LS_M));

  p_snoop_inval_r5: assert property (@(posedge clk) disable iff (rst)
    (commit && !is_owner && bus_wr) |=> (st == LS_I));

  p_nack_refill_r8: assert property (@(posedge clk) disable iff (rst)
    (commit && is_owner && !bus_wr && want_wr) |=> (ph == C_WAIT && st != LS_I));
endmodule

// File: rtl/mesi_snoop_bus.sv
module mesi_snoop_bus
  import mesi_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_valid,
  input  logic [2*N-1:0]       req_op,
  input  logic [N*W-1:0]       req_data,
  output logic [N-1:0]         req_done,
  output logic [N*W-1:0]       rsp_data,
  output logic [2*N-1:0]       line_state,
  output logic [W-1:0]         mem_word,
  output logic                 bus_valid,
  output logic [$clog2(N)-1:0] bus_owner,
  output logic                 bus_wr,
  output logic                 bus_nack
);
  localparam int IW = $clog2(N);

  logic [N*W-1:0] data_flat;
  logic [N-1:0]   ack;
  logic [N-1:0]   bus_req;
  logic [N-1:0]   want_wr;
  logic           commit;
  logic           shared;
  logic [W-1:0]   fill_data;
  logic [N-1:0]   excl_v;
  logic [N-1:0]   sh_v;

  mesi_bus_ctl #(.N(N), .W(W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .want_wr   (want_wr),
    .st_flat   (line_state),
    .data_flat (data_flat),
    .ack       (ack),
    .bus_valid (bus_valid),
    .owner     (bus_owner),
    .bus_wr    (bus_wr),
    .bus_nack  (bus_nack),
    .commit    (commit),
    .shared    (shared),
    .fill_data (fill_data),
    .mem_word  (mem_word)
  );

  for (genvar g = 0; g < N; g++) begin : g_core
    mesi_line_ctrl #(.N(N), .W(W), .IDX(g)) u_line (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid[g]),
      .req_op    (req_op[2*g +: 2]),
      .req_data  (req_data[g*W +: W]),
      .bus_valid (bus_valid),
      .owner     (bus_owner),
      .bus_wr    (bus_wr),
      .commit    (commit),
      .shared    (shared),
      .fill_data (fill_data),
      .st_o      (line_state[2*g +: 2]),
      .data_o    (data_flat[g*W +: W]),
      .bus_req   (bus_req[g]),
      .want_wr   (want_wr[g]),
      .ack       (ack[g]),
      .req_done  (req_done[g]),
      .rsp_data  (rsp_data[g*W +: W])
    );
    assign excl_v[g] = (line_state[2*g +: 2] == LS_M) || (line_state[2*g +: 2] == LS_E);
    assign sh_v[g]   = (line_state[2*g +: 2] == LS_S);
  end

  p_single_writer_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(excl_v) <= 1) && !((|excl_v) && (|sh_v)));
endmodule

// File: tb/mesi_snoop_bus_tb.sv
module mesi_snoop_bus_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   req_valid;
  logic [2*N-1:0] req_op;
  logic [N*W-1:0] req_data;
  logic [N-1:0]   req_done;
  logic [N*W-1:0] rsp_data;
  logic [2*N-1:0] line_state;
  logic [W-1:0]   mem_word;
  logic           bus_valid;
  logic [1:0]     bus_owner;
  logic           bus_wr;
  logic           bus_nack;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int got [N];
  int lat [N];
  int st_cyc [N];
  bit fin [N];
  int gq [$];
  int nq [$];
  int run = 0;
  int last_run = 0;
  bit prev_bv = 1'b0;
  bit model_ok = 1'b0;
  logic [2*N-1:0] exp_ls;
  int exp_mem;

  mesi_snoop_bus #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_done(req_done), .rsp_data(rsp_data),
    .line_state(line_state), .mem_word(mem_word), .bus_valid(bus_valid),
    .bus_owner(bus_owner), .bus_wr(bus_wr), .bus_nack(bus_nack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ls(input int c);
    return int'(line_state[2*c +: 2]);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // completion capture and bus observation, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (req_valid[i] && req_done[i]) begin
          got[i] = int'(rsp_data[i*W +: W]);
          lat[i] = cyc - st_cyc[i];
          fin[i] = 1'b1;
          req_valid[i] = 1'b0;
        end
      end
      if (bus_valid && !prev_bv) begin
        gq.push_back(int'(bus_owner));
        if (bus_nack) nq.push_back(int'(bus_owner));
        run = 0;
      end
      if (bus_valid) run++;
      if (!bus_valid && prev_bv) last_run = run;
      prev_bv = bus_valid;
      begin : inv_r10
        int nx;
        int ns;
        nx = 0;
        ns = 0;
        for (int i = 0; i < N; i++) begin
          if (ls(i) >= 2) nx++;
          if (ls(i) == 1) ns++;
        end
        chk("R10 single writer", int'(nx > 1 || (nx == 1 && ns > 0)), 0);
      end
      if (model_ok && req_valid == '0 && !bus_valid) begin
        chk("R2 model line_state", int'(line_state), int'(exp_ls));
        chk("R3 model mem_word", int'(mem_word), exp_mem);
      end
    end
  end

  task automatic start(input int c, input int op, input int d);
    model_ok = 1'b0;
    req_op[2*c +: 2] = op[1:0];
    req_data[c*W +: W] = d[W-1:0];
    fin[c] = 1'b0;
    st_cyc[c] = cyc;
    req_valid[c] = 1'b1;
  endtask

  task automatic wait_fin(input int c);
    int n;
    n = 0;
    while (!fin[c] && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (!fin[c]) chk("R6 request completes", 0, 1);
  endtask

  task automatic do_reset();
    model_ok = 1'b0;
    rst = 1'b1;
    req_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gq.delete();
    nq.delete();
    prev_bv = 1'b0;
    exp_ls = '0;
    exp_mem = 0;
  endtask

  task automatic set_model(input logic [2*N-1:0] s, input int m);
    exp_ls = s;
    exp_mem = m;
    model_ok = 1'b1;
  endtask

  initial begin
    rst = 1'b1;
    req_valid = '0;
    req_op = '0;
    req_data = '0;
    for (int i = 0; i < N; i++) fin[i] = 1'b0;

    // reset state
    do_reset();
    chk("R1 line_state", int'(line_state), 0);
    chk("R1 mem_word", int'(mem_word), 0);
    chk("R1 req_done", int'(req_done), 0);
    chk("R1 bus_valid", int'(bus_valid), 0);
    set_model('0, 0);

    // miss, local write, snooped writeback, upgrade
    start(0, 0, 0); wait_fin(0);
    chk("R2 miss exclusive", ls(0), 2);
    chk("R2 miss data", got[0], 0);
    chk("R11 miss latency", lat[0], 3);
    set_model(8'b00_00_00_10, 0);
    start(0, 1, 'h55); wait_fin(0);
    chk("R4 local write M", ls(0), 3);
    chk("R4 local write latency", lat[0], 1);
    chk("R4 no bus transaction", gq.size(), 1);
    set_model(8'b00_00_00_11, 0);
    start(1, 0, 0); wait_fin(1);
    chk("R3 reader gets dirty word", got[1], 'h55);
    chk("R3 writeback mem", int'(mem_word), 'h55);
    chk("R3 old owner shared", ls(0), 1);
    chk("R2 reader shared", ls(1), 1);
    set_model(8'b00_00_01_01, 'h55);
    start(1, 1, 'h66); wait_fin(1);
    chk("R5 writer M", ls(1), 3);
    chk("R5 other invalid", ls(0), 0);
    chk("R11 upgrade latency", lat[1], 3);
    set_model(8'b00_00_11_00, 'h55);
    start(2, 0, 0); wait_fin(2);
    chk("R3 second writeback", got[2], 'h66);
    set_model(8'b00_01_01_00, 'h66);
    start(1, 0, 0); wait_fin(1);
    chk("R11 hit latency", lat[1], 1);
    chk("R11 hit data", got[1], 'h66);

    // round robin
    do_reset();
    set_model('0, 0);
    start(2, 0, 0); wait_fin(2);
    start(0, 0, 0); start(3, 0, 0);
    wait_fin(0); wait_fin(3);
    chk("R6 one grant per read", gq.size(), 3);
    chk("R7 first grant after previous", gq[1], 3);
    chk("R7 wrapped grant", gq[2], 0);
    chk("R2 three sharers", int'(line_state), int'(8'b01_01_00_01));
    set_model(8'b01_01_00_01, 0);

    // NACK and retry
    do_reset();
    set_model('0, 0);
    start(0, 0, 0); wait_fin(0);
    start(1, 0, 0); wait_fin(1);
    set_model(8'b00_00_01_01, 0);
    start(0, 1, 'h11); start(1, 1, 'h22);
    wait_fin(0); wait_fin(1);
    chk("R8 one nack", nq.size(), 1);
    if (nq.size() > 0) chk("R8 nack owner", nq[0], 1);
    chk("R8 grant count", gq.size(), 5);
    if (gq.size() == 5) begin
      chk("R7 write grant order", gq[2], 0);
      chk("R8 refill then retry", gq[3] * 10 + gq[4], 11);
    end
    chk("R8 final owner M", ls(1), 3);
    chk("R8 loser invalid", ls(0), 0);
    chk("R3 refill writeback", int'(mem_word), 'h11);
    set_model(8'b00_00_11_00, 'h11);
    start(0, 0, 0); wait_fin(0);
    chk("R3 read after retry", got[0], 'h22);
    set_model(8'b00_00_01_01, 'h22);

    // locked add with a concurrent reader
    do_reset();
    set_model('0, 0);
    start(0, 1, 5); wait_fin(0);
    chk("R8 write from invalid nacks", nq.size(), 1);
    chk("R8 write from invalid ends M", ls(0), 3);
    set_model(8'b00_00_00_11, 0);
    start(0, 2, 3); start(1, 0, 0);
    wait_fin(0); wait_fin(1);
    chk("R9 add returns old", got[0], 5);
    chk("R11 add latency", lat[0], 4);
    chk("R9 reader sees sum", got[1], 8);
    chk("R9 snoop held off", last_run, 3);
    chk("R9 mem after add", int'(mem_word), 8);
    set_model(8'b00_00_01_01, 8);
    start(2, 2, 10); wait_fin(2);
    chk("R9 add from invalid old", got[2], 8);
    chk("R9 add owner M", ls(2), 3);
    chk("R8 add from invalid nacks", nq.size(), 2);
    set_model(8'b00_11_00_00, 8);
    start(2, 0, 0); wait_fin(2);
    chk("R9 sum stored", got[2], 18);
    chk("R11 hit after add", lat[2], 1);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule